// File: doc/BRIEF.md
# Periodic Clock-Rate Trim Unit

This unit corrects the rate of a 32.768 kHz time base. Once per correction interval it either inserts extra prescaler advances or swallows some, so that a crystal running slightly fast or slow still yields an accurate second. The interval is 20 or 60 seconds. The same step count therefore gives a coarse adjustment of roughly 3051 ppb per step in the short interval, or a fine one of roughly 1017 ppb per step in the long interval. One step is always two prescaler pulses.

Software writes one 8-bit trim word:

- bit 7 picks the long interval.
- bit 6 picks removal rather than insertion.
- bits 5:0 hold a step code.

The unit does not apply a new word at once. It keeps the word pending and raises a busy flag. At the next interval boundary it moves the word into the working register and lowers the flag. The correction starts right after that boundary.

Downstream logic reads the `adv_cnt` output each cycle and advances its prescaler by that many counts. The value is 1 on a normal 32 kHz enable, 2 on an enable that inserts an extra pulse, and 0 on an enable that swallows one.

Top module: `trim_unit`

## Requirements
- R1: After reset the busy flag is low, the working and pending words are zero, and no correction is applied.
- R2: When no correction is in progress, `adv_cnt` is 1 in a cycle with `tick32k` high and 0 in a cycle with `tick32k` low.
- R3: A write (`wr_en` high) while busy is low captures `wr_data` as the pending word, and busy is high from the following cycle.
- R4: A write while busy is high is ignored. The pending word is unchanged, so the correction applied later is that of the first write.
- R5: Busy falls, and the pending word becomes the working word, only at an interval boundary. An interval boundary is a `sec_tick` cycle on which the interval's last second completes.
- R6: The interval is 60 seconds when working bit 7 is 1 and 20 seconds when it is 0. The second counter starts at zero after reset and restarts at zero on each boundary.
- R7: With working bit 6 at 0 and step code c ≥ 1, the 2·(c−1) `tick32k` cycles that follow the boundary give `adv_cnt` = 2. A code of 1 gives no correction.
- R8: With working bit 6 at 1 and step code c ≥ 1, the 2·((~c & 63)+1) `tick32k` cycles that follow the boundary give `adv_cnt` = 0. This count is 4 for c = 62 and 126 for c = 1.
- R9: A step code of 0 gives no correction, whatever the value of bit 6.
- R10: While `trim_en` is low, every `tick32k` gives `adv_cnt` = 1, and any correction still in progress is cancelled for good.
- R11: `adv_cnt` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| sec_tick | input | 1 | One-cycle enable, once per second |
| trim_en | input | 1 | High selects trim operation |
| wr_en | input | 1 | Write strobe for the trim word |
| wr_data | input | 8 | Trim word: [7] long interval, [6] remove, [5:0] step code |
| adv_cnt | output | 2 | Prescaler advance for this cycle (0, 1 or 2) |
| busy | output | 1 | A written trim word is waiting for the next boundary |

## Verification
The bench targets the extreme step codes:

- Insertion at code 1 must give zero pulses. A design that used c instead of c−1 would insert two.
- Removal at code 1 must give the full 126-pulse window. An encoding inverted the wrong way would swallow only 2 pulses.

For the interval rules, the bench counts the seconds between two boundaries in each mode. A design that read the interval bit from the pending word rather than the working word would end the 60-second interval after 20 seconds.

The remaining cases are:

- A write issued while busy, which a careless design would let overwrite the pending word.
- Removal with a zero code, which a design ignoring the zero rule would treat as 64 steps.
- Disabling trim in the middle of a correction, which must not let the cancelled pulses resume afterwards.

// File: rtl/trim_unit.sv
module trim_unit #(
  parameter int SHORT_SEC = 20,
  parameter int LONG_SEC  = 60,
  parameter int CODE_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick32k,
  input  logic              sec_tick,
  input  logic              trim_en,
  input  logic              wr_en,
  input  logic [CODE_W+1:0] wr_data,
  output logic [1:0]        adv_cnt,
  output logic              busy
);
  localparam int REG_W    = CODE_W + 2;
  localparam int LONG_BIT = CODE_W + 1;
  localparam int SUB_BIT  = CODE_W;
  localparam int SEC_W    = $clog2(LONG_SEC);
  localparam int CNT_W    = CODE_W + 2;

  logic [REG_W-1:0] work_q, pend_q;
  logic             busy_q;
  logic [SEC_W-1:0] sec_q;
  logic [CNT_W-1:0] rem_q;

  function automatic logic [CNT_W-1:0] pulses(input logic [REG_W-1:0] w);
    logic [CODE_W-1:0] c;
    logic [CNT_W-1:0]  s;
    c = w[CODE_W-1:0];
    if (c == '0)
      s = '0;                                              // R9
    else if (w[SUB_BIT])
      s = {{(CNT_W-CODE_W){1'b0}}, ~c} + CNT_W'(1);        // R8
    else
      s = {{(CNT_W-CODE_W){1'b0}}, c} - CNT_W'(1);         // R7
    return s << 1;
  endfunction

  logic [SEC_W-1:0] last_sec;
  logic             boundary;
  logic [REG_W-1:0] next_work;
  logic             correcting;

  // R6: interval length follows the working word
  assign last_sec   = work_q[LONG_BIT] ? SEC_W'(LONG_SEC - 1) : SEC_W'(SHORT_SEC - 1);
  assign boundary   = sec_tick && (sec_q >= last_sec);
  assign next_work  = busy_q ? pend_q : work_q;
  assign correcting = trim_en && (rem_q != '0);

  // R2, R7, R8, R10
  assign adv_cnt = !tick32k   ? 2'd0 :
                   !correcting ? 2'd1 :
                   work_q[SUB_BIT] ? 2'd0 : 2'd2;
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
      sec_q  <= '0;
      rem_q  <= '0;
    end else begin
      if (wr_en && !busy_q) begin        // R3, R4
        pend_q <= wr_data;
        busy_q <= 1'b1;
      end
      if (sec_tick)
        sec_q <= boundary ? '0 : sec_q + SEC_W'(1);
      if (boundary) begin                // R5
        work_q <= next_work;
        if (busy_q) busy_q <= 1'b0;
        rem_q  <= trim_en ? pulses(next_work) : '0;
      end else if (!trim_en) begin
        rem_q <= '0;
      end else if (tick32k && rem_q != '0) begin
        rem_q <= rem_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/trim_unit_chk.sv
module trim_unit_chk #(
  parameter int LONG_SEC = 60,
  parameter int CODE_W   = 6,
  parameter int SEC_W    = 6,
  parameter int CNT_W    = 8,
  parameter int REG_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick32k,
  input logic             sec_tick,
  input logic             trim_en,
  input logic             wr_en,
  input logic [1:0]       adv_cnt,
  input logic             busy,
  input logic [SEC_W-1:0] sec,
  input logic [CNT_W-1:0] rem,
  input logic [REG_W-1:0] work
);
  localparam int MAX_PULSES = 2 * (2 ** CODE_W - 1);

  p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick32k |-> adv_cnt == 2'd0);
  p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trim_en && tick32k) |-> adv_cnt == 2'd1);
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_en |=> rem == '0);
  p_adv_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    adv_cnt != 2'd3);
  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sec_tick) |=> busy);
  p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sec_tick));
  p_work_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(work));
  p_sec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec < SEC_W'(LONG_SEC));
  p_rem_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= CNT_W'(MAX_PULSES));
endmodule

bind trim_unit trim_unit_chk #(
  .LONG_SEC(LONG_SEC), .CODE_W(CODE_W), .SEC_W(SEC_W), .CNT_W(CNT_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick32k(tick32k), .sec_tick(sec_tick),
  .trim_en(trim_en), .wr_en(wr_en), .adv_cnt(adv_cnt), .busy(busy),
  .sec(sec_q), .rem(rem_q), .work(work_q)
);

// File: tb/trim_unit_tb.sv
module trim_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick32k = 1'b0, sec_tick = 1'b0, trim_en = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] adv_cnt;
  logic       busy;

  always #4 clk = ~clk;

  trim_unit u_dut (.clk(clk), .rst_n(rst_n), .tick32k(tick32k), .sec_tick(sec_tick),
                   .trim_en(trim_en), .wr_en(wr_en), .wr_data(wr_data),
                   .adv_cnt(adv_cnt), .busy(busy));

  int n_chk = 0, n_fail = 0, cyc_n = 0;
  bit en_req = 1'b1;
  logic [7:0] m_work = '0, m_pend = '0;
  bit m_busy = 1'b0;
  int m_sec = 0, m_rem = 0;
  int w_add = 0, w_sub = 0, w_sec_busy = 0;
  bit done = 1'b0;

  function automatic int pulses(logic [7:0] v);
    int c;
    c = int'(v[5:0]);
    if (c == 0) return 0;
    if (v[6]) return 2 * (((~c) & 63) + 1);
    return 2 * (c - 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit w, logic [7:0] d);
    int exp_adv, len;
    logic [7:0] nw, np;
    bit nb;
    int ns, nr;
    @(negedge clk);
    tick32k  = (cyc_n % 2 == 0);
    sec_tick = (cyc_n % 300 == 150);
    trim_en  = en_req;
    wr_en    = w;
    wr_data  = d;
    cyc_n++;
    #1;
    if (!tick32k) exp_adv = 0;
    else if (trim_en && m_rem > 0) exp_adv = m_work[6] ? 0 : 2;
    else exp_adv = 1;
    chk(int'(adv_cnt) == exp_adv,
        (trim_en && m_rem > 0) ? (m_work[6] ? "R8 adv" : "R7 adv") : "R2 adv",
        int'(adv_cnt), exp_adv);
    chk(busy == m_busy, "R3/R4/R5 busy", int'(busy), int'(m_busy));
    if (sec_tick) begin
      w_add = 0;
      w_sub = 0;
      if (busy) w_sec_busy++;
    end
    if (adv_cnt == 2'd2) w_add++;
    if (tick32k && adv_cnt == 2'd0) w_sub++;
    nw = m_work; np = m_pend; nb = m_busy; ns = m_sec; nr = m_rem;
    if (wr_en && !m_busy) begin np = wr_data; nb = 1'b1; end
    if (!trim_en) nr = 0;
    else if (tick32k && m_rem > 0) nr = m_rem - 1;
    if (sec_tick) begin
      len = m_work[7] ? 60 : 20;
      if (m_sec >= len - 1) begin
        ns = 0;
        if (m_busy) begin nw = m_pend; nb = 1'b0; end
        nr = trim_en ? pulses(nw) : 0;
      end else ns = m_sec + 1;
    end
    m_work = nw; m_pend = np; m_busy = nb; m_sec = ns; m_rem = nr;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00);
  endtask

  task automatic wait_fall(string req);
    bit seen;
    bit prev;
    seen = 1'b0;
    prev = busy;
    for (int i = 0; i < 25000 && !seen; i++) begin
      cyc(1'b0, 8'h00);
      if (prev && !busy) seen = 1'b1;
      prev = busy;
    end
    chk(seen, req, 0, 1);
  endtask

  initial begin
    int snap;
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    rst_n = 1'b1;
    run(700);
    chk(w_add == 0 && w_sub == 0, "R1 no correction", w_add + w_sub, 0);

    cyc(1'b1, 8'h05);
    run(1);
    chk(busy == 1'b1, "R3 busy after write", int'(busy), 1);
    run(5);
    cyc(1'b1, 8'h3F);
    wait_fall("R5 boundary reached");
    run(260);
    chk(w_add == 8, "R7 add code 5", w_add, 8);
    chk(w_add != 124, "R4 ignored write", w_add, 8);

    cyc(1'b1, 8'hFE);
    wait_fall("R5 boundary reached");
    run(260);
    chk(w_sub == 4, "R8 remove code 62", w_sub, 4);
    w_sec_busy = 0;
    cyc(1'b1, 8'h41);
    wait_fall("R5 boundary reached");
    chk(w_sec_busy == 60, "R6 long interval seconds", w_sec_busy, 60);
    run(260);
    chk(w_sub == 126, "R8 remove code 1", w_sub, 126);

    w_sec_busy = 0;
    cyc(1'b1, 8'hC0);
    wait_fall("R5 boundary reached");
    chk(w_sec_busy == 20, "R6 short interval seconds", w_sec_busy, 20);
    run(260);
    chk(w_add == 0 && w_sub == 0, "R9 remove code 0", w_add + w_sub, 0);

    cyc(1'b1, 8'h3F);
    wait_fall("R5 boundary reached");
    run(40);
    en_req = 1'b0;
    run(20);
    chk(w_add > 0 && w_add < 124, "R10 partial before disable", w_add, 20);
    en_req = 1'b1;
    snap = w_add;
    run(180);
    chk(w_add == snap, "R10 cancelled correction", w_add, snap);

    cyc(1'b1, 8'h01);
    wait_fall("R5 boundary reached");
    run(260);
    chk(w_add == 0 && w_sub == 0, "R7 add code 1", w_add + w_sub, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(190000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule